// File: doc/BRIEF.md
# Low-Power Halt Sequencer

This block sequences a core through its deepest sleep state and back. When the processor executes its idle instruction in halt configuration, it raises a halt request. The sequencer then keeps every clock running for a fixed drain window, so that the pipeline and outstanding transactions can complete. After that window it gates the core and peripheral clocks, turns the PLL off and, when the clock comes from a crystal or resonator, also stops the on-chip oscillator. An externally driven clock input keeps the oscillator enabled.

Wake-up starts with a falling edge on the wake pin. That edge is captured by an asynchronous set/clear flag, so it is seen even though no clock is running, and the flag re-enables the oscillator at once. The synchronised flag then moves the sequencer through three counted phases: oscillator settling, PLL lock and a resume window. Clocks come back at the start of the resume window. The analog oscillator and PLL appear here only as enable outputs, and the phase lengths are counted on the one modelled clock `clk`. A 3-bit status output reports the current phase.

Top module: `hm_halt_seq`

## Requirements
- R1: While `rst_n` is low and right after it rises, `status` reads RUN (3'd0) and `core_clk_en`, `periph_clk_en`, `pll_en` and `osc_en` are all high.
- R2: When `halt_req` is sampled high in RUN, `status` shows DRAIN (3'd1) for exactly DRAIN_CYC (32) cycles with all enables still high. The core clock gate therefore closes 32 cycles after the request.
- R3: In HALT (3'd2), `core_clk_en`, `periph_clk_en` and `pll_en` are low.
- R4: In HALT, `osc_en` is low when `osc_is_xtal` is 1 (crystal or resonator) and high when `osc_is_xtal` is 0 (external clock input), until a wake edge arrives.
- R5: A falling edge on `wake_n` in HALT raises `osc_en` immediately, without any clock edge. Even a low pulse much shorter than a clock period is kept. `status` changes to OSC_START (3'd3) on the third rising clock edge after the falling edge.
- R6: OSC_START lasts exactly OSC_START_CYC cycles when `wake_n` has returned high in time. During OSC_START, `osc_en` is high and `pll_en`, `core_clk_en` and `periph_clk_en` are low.
- R7: The sequencer does not leave OSC_START while the synchronised `wake_n` is still low. Once the pin is released after the settling count has expired, PLL_LOCK appears on the third rising edge after the release.
- R8: PLL_LOCK (3'd4) lasts exactly PLL_LOCK_CYC (2600) cycles with `pll_en` and `osc_en` high and the core and peripheral clocks gated.
- R9: RESUME (3'd5) lasts exactly RESUME_CYC (35) cycles with the core and peripheral clocks enabled, then `status` returns to RUN.
- R10: A `halt_req` outside RUN is ignored: a request held high through a wake sequence has no effect until the sequencer is back in RUN. Falling edges on `wake_n` outside HALT are also ignored.
- R11: `status` only ever takes the six codes 3'd0 to 3'd5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, free-running in this model |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt entry request from the idle instruction |
| wake_n | input | 1 | Wake pin; a falling edge starts the exit from HALT |
| osc_is_xtal | input | 1 | 1 = crystal or resonator source, 0 = external clock input |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | On-chip oscillator enable |
| status | output | 3 | Current phase: RUN 0, DRAIN 1, HALT 2, OSC_START 3, PLL_LOCK 4, RESUME 5 |

## Verification
The assertions assume that `osc_is_xtal` stays constant for a whole halt sequence. They also assume that the wake pin makes a single clean falling edge per HALT visit, with no glitches while the flag is being synchronised. The bench changes the source select only while the sequencer is in RUN. It drives `wake_n` one nanosecond after a falling clock edge, makes exactly one low pulse per wake-up, and releases that pulse either inside the settling window or, in the directed long-pulse case, well after it.

// File: rtl/hm_pkg.sv
package hm_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_DRAIN  = 3'd1,
    ST_HALT   = 3'd2,
    ST_OSC    = 3'd3,
    ST_LOCK   = 3'd4,
    ST_RESUME = 3'd5
  } hm_state_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // clocks to core and peripherals run in these phases only
  function automatic logic clocks_on(input hm_state_e st);
    return (st == ST_RUN) || (st == ST_DRAIN) || (st == ST_RESUME);
  endfunction

  // PLL is off while halted and while the oscillator settles
  function automatic logic pll_on(input hm_state_e st);
    return (st != ST_HALT) && (st != ST_OSC);
  endfunction

  // oscillator stays on for an external clock, or once a wake edge is seen
  function automatic logic osc_on(input hm_state_e st, input logic xtal, input logic wake_seen);
    if (st == ST_HALT) return !xtal || wake_seen;
    return 1'b1;
  endfunction

endpackage

// File: rtl/hm_phase_counter.sv
module hm_phase_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] last,
  output logic         done
);
  logic [W-1:0] cnt_q;

  assign done = (cnt_q == last);

  // saturates at the terminal value until cleared on a phase change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (!done) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hm_wake_latch.sv
module hm_wake_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_n,
  input  logic arm,
  output logic wake_flag,
  output logic wake_evt,
  output logic wake_hi
);
  logic       clr_q;
  logic       flag_q;
  logic [1:0] flag_sync_q;
  logic [1:0] pin_sync_q;

  // flag is held clear except while the next state is HALT
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b1;
    else        clr_q <= !arm;
  end

  // set by the pin edge itself: works with every clock stopped
  always_ff @(negedge wake_n or posedge clr_q) begin
    if (clr_q) flag_q <= 1'b0;
    else       flag_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_sync_q <= 2'b00;
      pin_sync_q  <= 2'b11;
    end else begin
      flag_sync_q <= {flag_sync_q[0], flag_q};
      pin_sync_q  <= {pin_sync_q[0], wake_n};
    end
  end

  assign wake_flag = flag_q;
  assign wake_evt  = flag_sync_q[1];
  assign wake_hi   = pin_sync_q[1];
endmodule

// File: rtl/hm_clk_ctrl.sv
module hm_clk_ctrl
  import hm_pkg::*;
(
  input  hm_state_e state,
  input  logic      osc_is_xtal,
  input  logic      wake_flag,
  output logic      core_clk_en,
  output logic      periph_clk_en,
  output logic      pll_en,
  output logic      osc_en
);
  assign core_clk_en   = clocks_on(state);
  assign periph_clk_en = clocks_on(state);
  assign pll_en        = pll_on(state);
  assign osc_en        = osc_on(state, osc_is_xtal, wake_flag);
endmodule

// File: rtl/hm_halt_seq.sv
module hm_halt_seq
  import hm_pkg::*;
#(
  parameter int unsigned DRAIN_CYC     = 32,
  parameter int unsigned OSC_START_CYC = 16,
  parameter int unsigned PLL_LOCK_CYC  = 2600,
  parameter int unsigned RESUME_CYC    = 35
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       wake_n,
  input  logic       osc_is_xtal,
  output logic       core_clk_en,
  output logic       periph_clk_en,
  output logic       pll_en,
  output logic       osc_en,
  output logic [2:0] status
);
  localparam int unsigned MAX_LEN = max4(DRAIN_CYC, OSC_START_CYC, PLL_LOCK_CYC, RESUME_CYC);
  localparam int CNT_W = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

  hm_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_last;
  logic           cnt_done;
  logic           wake_flag, wake_evt, wake_hi;

  // named phase events, also used by the checker
  logic drain_done, osc_done, lock_done, resume_done;

  assign drain_done  = (state_q == ST_DRAIN)  && cnt_done;
  assign osc_done    = (state_q == ST_OSC)    && cnt_done;
  assign lock_done   = (state_q == ST_LOCK)   && cnt_done;
  assign resume_done = (state_q == ST_RESUME) && cnt_done;

  always_comb begin
    case (state_q)
      ST_DRAIN:  cnt_last = CNT_W'(DRAIN_CYC - 1);
      ST_OSC:    cnt_last = CNT_W'(OSC_START_CYC - 1);
      ST_LOCK:   cnt_last = CNT_W'(PLL_LOCK_CYC - 1);
      ST_RESUME: cnt_last = CNT_W'(RESUME_CYC - 1);
      default:   cnt_last = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:    if (halt_req)            state_d = ST_DRAIN;
      ST_DRAIN:  if (drain_done)          state_d = ST_HALT;
      ST_HALT:   if (wake_evt)            state_d = ST_OSC;
      ST_OSC:    if (osc_done && wake_hi) state_d = ST_LOCK;
      ST_LOCK:   if (lock_done)           state_d = ST_RESUME;
      ST_RESUME: if (resume_done)         state_d = ST_RUN;
      default:                            state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  hm_phase_counter #(.W(CNT_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_d != state_q),
    .last  (cnt_last),
    .done  (cnt_done)
  );

  hm_wake_latch wake_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake_n    (wake_n),
    .arm       (state_d == ST_HALT),
    .wake_flag (wake_flag),
    .wake_evt  (wake_evt),
    .wake_hi   (wake_hi)
  );

  hm_clk_ctrl ctrl_i (
    .state         (state_q),
    .osc_is_xtal   (osc_is_xtal),
    .wake_flag     (wake_flag),
    .core_clk_en   (core_clk_en),
    .periph_clk_en (periph_clk_en),
    .pll_en        (pll_en),
    .osc_en        (osc_en)
  );

  assign status = state_q;
endmodule

// File: rtl/hm_halt_seq_chk.sv
module hm_halt_seq_chk
  import hm_pkg::*;
#(
  parameter int unsigned DRAIN_CYC    = 32,
  parameter int unsigned PLL_LOCK_CYC = 2600,
  parameter int unsigned RESUME_CYC   = 35
) (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_is_xtal,
  input logic [2:0] status,
  input logic       core_clk_en,
  input logic       periph_clk_en,
  input logic       pll_en,
  input logic       osc_en,
  input logic       wake_evt
);
  logic [15:0] dcnt_q, lcnt_q, rcnt_q;

  // length of the current DRAIN, PLL_LOCK and RESUME visits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      lcnt_q <= '0;
      rcnt_q <= '0;
    end else begin
      dcnt_q <= (status == ST_DRAIN)  ? dcnt_q + 16'd1 : 16'd0;
      lcnt_q <= (status == ST_LOCK)   ? lcnt_q + 16'd1 : 16'd0;
      rcnt_q <= (status == ST_RESUME) ? rcnt_q + 16'd1 : 16'd0;
    end
  end

  // R2
  drain_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_HALT && $past(status) == ST_DRAIN) |-> dcnt_q == 16'(DRAIN_CYC));

  // R3
  halt_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_HALT) |-> (!core_clk_en && !periph_clk_en && !pll_en));

  // R4
  ext_osc_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_HALT && !osc_is_xtal) |-> osc_en);

  // R5
  wake_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_HALT && wake_evt) |=> status == ST_OSC);

  // R6
  osc_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_OSC) |-> (osc_en && !pll_en && !core_clk_en));

  // R8
  lock_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_RESUME && $past(status) == ST_LOCK) |-> lcnt_q == 16'(PLL_LOCK_CYC));

  // R8
  lock_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_LOCK) |-> (pll_en && osc_en && !periph_clk_en));

  // R9
  resume_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_RUN && $past(status) == ST_RESUME) |-> rcnt_q == 16'(RESUME_CYC));

  // R10
  no_late_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != ST_RUN && status != ST_DRAIN) |=> status != ST_DRAIN);

  // R11
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status <= 3'd5);
endmodule

bind hm_halt_seq hm_halt_seq_chk #(
  .DRAIN_CYC    (DRAIN_CYC),
  .PLL_LOCK_CYC (PLL_LOCK_CYC),
  .RESUME_CYC   (RESUME_CYC)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .osc_is_xtal   (osc_is_xtal),
  .status        (status),
  .core_clk_en   (core_clk_en),
  .periph_clk_en (periph_clk_en),
  .pll_en        (pll_en),
  .osc_en        (osc_en),
  .wake_evt      (wake_evt)
);

// File: tb/hm_halt_seq_tb_top.sv
`timescale 1ns/1ps
module hm_halt_seq_tb_top;
  localparam int DRAIN = 32;
  localparam int OSC   = 20;
  localparam int LOCK  = 2600;
  localparam int RES   = 35;

  localparam logic [2:0] S_RUN = 3'd0, S_DRAIN = 3'd1, S_HALT = 3'd2,
                         S_OSC = 3'd3, S_LOCK  = 3'd4, S_RES  = 3'd5;

  // {osc_is_xtal, release index of the wake pulse inside OSC_START}
  localparam int NVEC = 4;
  localparam logic [8:0] VEC [NVEC] = '{9'h100, 9'h104, 9'h00A, 9'h010};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 1'b0;
  logic wake_n = 1'b1;
  logic osc_is_xtal = 1'b1;
  logic core_clk_en, periph_clk_en, pll_en, osc_en;
  logic [2:0] status;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hm_halt_seq #(
    .DRAIN_CYC(DRAIN), .OSC_START_CYC(OSC), .PLL_LOCK_CYC(LOCK), .RESUME_CYC(RES)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wake_n(wake_n),
    .osc_is_xtal(osc_is_xtal), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .pll_en(pll_en), .osc_en(osc_en), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_phase(input logic [2:0] st, output int n);
    n = 0;
    while (status == st && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic enter_halt(output int n);
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    chk(status == S_DRAIN && core_clk_en && pll_en, "R2 drain entry", int'(status), S_DRAIN);
    count_phase(S_DRAIN, n);
    chk(n == DRAIN, "R2 drain length", n, DRAIN);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(status == S_RUN, "R1 status in reset", int'(status), S_RUN);
    chk(core_clk_en && periph_clk_en && pll_en && osc_en, "R1 enables in reset",
        int'({core_clk_en, periph_clk_en, pll_en, osc_en}), 15);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == S_RUN, "R1 status after reset", int'(status), S_RUN);

    // R10: wake edges while running change nothing
    wake_n = 1'b0; @(negedge clk); wake_n = 1'b1; @(negedge clk);
    wake_n = 1'b0; #1 wake_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(status == S_RUN && core_clk_en && osc_en, "R10 wake ignored in RUN", int'(status), S_RUN);

    for (int i = 0; i < NVEC; i++) begin
      logic xt;
      int rel;
      xt  = VEC[i][8];
      rel = int'(VEC[i][7:0]);
      osc_is_xtal = xt;
      enter_halt(n);
      // R3 / R4
      chk(status == S_HALT, "R3 halt reached", int'(status), S_HALT);
      chk(!core_clk_en && !periph_clk_en && !pll_en, "R3 clocks gated",
          int'({core_clk_en, periph_clk_en, pll_en}), 0);
      repeat (3) @(negedge clk);
      chk(osc_en == !xt, "R4 osc enable in halt", int'(osc_en), int'(!xt));
      // R5 asynchronous wake
      #1 wake_n = 1'b0;
      #1 chk(osc_en == 1'b1, "R5 osc restarts without clock", int'(osc_en), 1);
      if (rel == 0) #1 wake_n = 1'b1;
      @(negedge clk);
      count_phase(S_HALT, n);
      chk(n == 2, "R5 wake latency", n, 2);
      // R6
      chk(osc_en && !pll_en && !core_clk_en, "R6 osc phase enables",
          int'({osc_en, pll_en, core_clk_en}), 4);
      n = 0;
      while (status == S_OSC && n < 1000) begin
        if (n == rel) wake_n = 1'b1;
        n++;
        @(negedge clk);
      end
      chk(n == OSC, "R6 osc settle length", n, OSC);
      // R8
      chk(status == S_LOCK && pll_en && osc_en && !core_clk_en, "R8 lock enables", int'(status), S_LOCK);
      count_phase(S_LOCK, n);
      chk(n == LOCK, "R8 lock length", n, LOCK);
      // R9
      chk(status == S_RES && core_clk_en && periph_clk_en, "R9 resume clocks on", int'(status), S_RES);
      count_phase(S_RES, n);
      chk(n == RES, "R9 resume length", n, RES);
      chk(status == S_RUN, "R9 back to run", int'(status), S_RUN);
    end

    // R7 long wake pulse, with R10 halt request held through the exit
    osc_is_xtal = 1'b1;
    enter_halt(n);
    #1 wake_n = 1'b0;
    @(negedge clk);
    count_phase(S_HALT, n);
    repeat (OSC + 5) @(negedge clk);
    chk(status == S_OSC, "R7 held in settle while pin low", int'(status), S_OSC);
    halt_req = 1'b1;
    wake_n = 1'b1;
    @(negedge clk);
    chk(status == S_OSC, "R7 first cycle after release", int'(status), S_OSC);
    @(negedge clk);
    chk(status == S_OSC, "R7 second cycle after release", int'(status), S_OSC);
    @(negedge clk);
    chk(status == S_LOCK, "R7 lock after sync", int'(status), S_LOCK);
    count_phase(S_LOCK, n);
    chk(n == LOCK, "R10 lock length with halt request held", n, LOCK);
    count_phase(S_RES, n);
    chk(n == RES, "R10 resume length with halt request held", n, RES);
    chk(status == S_RUN, "R10 run before new drain", int'(status), S_RUN);
    @(negedge clk);
    chk(status == S_DRAIN, "R2 held request honoured in RUN", int'(status), S_DRAIN);
    halt_req = 1'b0;

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule